// File: doc/BRIEF.md
# Page Access Counter Migration Trigger

This block sits beside one bank of a large shared cache built from many banks. It keeps a small set-associative table of recently seen physical pages. For each page it records how often each cluster of cores touches it, which cores have touched it, and how many accesses have gone by since the last new core joined. A cluster is a pair of adjacent cores. Each L1 request that reaches the bank is presented as a requesting core, a page number and a flag that says whether the bank is local to that core. One cycle later the block reports whether the page should move, and whether the move uses the solo rule or the shared rule. It also reports the page's current set of sharing cores.

Two run-time thresholds control the decision. The gap threshold is compared against the difference between the highest and second-highest cluster counts. The stability threshold is compared against the count of accesses since the last new sharer. Choosing the destination bank and moving the data are done elsewhere.

The controller has two states. ST_INIT walks through every set, one per cycle, clearing the valid bits and seeding the replacement ranks. Transition INIT_DONE leaves ST_INIT after the last set has been cleared. ST_RUN accepts requests and stays there until reset.

Top module: `pact_migrate_trigger`

## Requirements
- R1: While reset is asserted all outputs are 0. After reset is released the block spends SETS cycles in ST_INIT. A request presented in that time produces no decision (dec_valid stays 0) and leaves no trace in the table.
- R2: Every request accepted in ST_RUN produces dec_valid=1 exactly one clock later. In a cycle with no accepted request, dec_valid is 0 one clock later.
- R3: When req_home_local=1, dec_migrate is 0. The page's counters and sharer set are still updated.
- R4: The set index is page bits [SET_W-1:0] and the tag is the remaining upper bits. On a miss, the lowest-numbered invalid way is filled; if there is none, the least recently used way is filled. A new entry holds only the requester in its sharer set, a count of 1 for the requester's cluster, and 0 for every other counter.
- R5: On a hit by a core not yet in the sharer set, that core's bit is set, the sharer population rises by one, and the accesses-since-new-sharer counter returns to 0. On a hit by a core already in the set, that counter rises by one.
- R6: The accesses-since-new-sharer counter saturates at 2^SINCE_W-1 instead of wrapping.
- R7: The cluster of core c is c/2 (core bits above bit 0). Each cluster counter saturates at 2^CNT_W-1. The entry tracks the top count, the second count and the top cluster. A cluster that only equals the top count does not take over as top cluster.
- R8: The shared rule fires when the population is above 1, top minus second is below thr_gap, and accesses since the last new sharer exceed thr_since.
- R9: The solo rule fires when the population is exactly 1 or top minus second is at least thr_gap, and the requester's cluster is the top cluster.
- R10: dec_migrate is 1 when either rule fires and the bank is not local. dec_sharer_mode is 1 only when the move is by the shared rule, and is 0 otherwise. Bit i of dec_sharers is core i; it always contains the requester.
- R11: Each decision uses the thr_gap and thr_since values present in the cycle the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | An L1 request is present this cycle |
| req_core | input | $clog2(NUM_CORES) | Requesting core number |
| req_page | input | PAGE_W | Physical page number of the request |
| req_home_local | input | 1 | This bank is one of the requester's local banks |
| thr_gap | input | CNT_W | Threshold on top-minus-second cluster count |
| thr_since | input | SINCE_W | Threshold on accesses since the last new sharer |
| dec_valid | output | 1 | A decision is presented this cycle |
| dec_migrate | output | 1 | The page should move |
| dec_sharer_mode | output | 1 | 1: move by the shared rule; 0: by the solo rule or no move |
| dec_sharers | output | NUM_CORES | Sharer set of the page after this access |

## Verification
All four decision outputs are registered, so every result is due at the first rising edge after the request was accepted. The bench applies each request at a falling edge and reads the outputs at the next falling edge, half a period after that rising edge. An idle cycle between requests lets the bench confirm that dec_valid falls back to 0. Table state such as LRU order and counter saturation cannot be read directly. The bench infers it from later decisions and sharer sets, each sampled at that same one-cycle point, including requests issued during ST_INIT that must leave no decision behind.

// File: rtl/pact_pkg.sv
package pact_pkg;
    typedef enum logic {
        ST_INIT = 1'b0,
        ST_RUN  = 1'b1
    } pact_state_e;
endpackage

// File: rtl/pact_entry_update.sv
module pact_entry_update #(
    parameter int NUM_CORES = 8,
    parameter int CNT_W     = 6,
    parameter int SINCE_W   = 8,
    localparam int CORE_W   = $clog2(NUM_CORES),
    localparam int NUM_CL   = NUM_CORES / 2,
    localparam int CL_W     = CORE_W - 1,
    localparam int POP_W    = $clog2(NUM_CORES + 1),
    localparam int CNTS_W   = NUM_CL * CNT_W
) (
    input  logic                 hit,
    input  logic [CORE_W-1:0]    core,
    input  logic [CNTS_W-1:0]    old_cnts,
    input  logic [CNT_W-1:0]     old_top,
    input  logic [CNT_W-1:0]     old_sec,
    input  logic [CL_W-1:0]      old_topid,
    input  logic [NUM_CORES-1:0] old_vec,
    input  logic [POP_W-1:0]     old_pop,
    input  logic [SINCE_W-1:0]   old_since,
    output logic [CNTS_W-1:0]    new_cnts,
    output logic [CNT_W-1:0]     new_top,
    output logic [CNT_W-1:0]     new_sec,
    output logic [CL_W-1:0]      new_topid,
    output logic [NUM_CORES-1:0] new_vec,
    output logic [POP_W-1:0]     new_pop,
    output logic [SINCE_W-1:0]   new_since
);
    logic [CL_W-1:0]      cl;
    logic [CNT_W-1:0]     cur;
    logic [CNT_W-1:0]     inc;
    logic [NUM_CORES-1:0] bit_me;

    assign cl     = core[CORE_W-1:1];
    assign cur    = old_cnts[cl*CNT_W +: CNT_W];
    assign inc    = (cur == {CNT_W{1'b1}}) ? cur : cur + 1'b1;
    assign bit_me = NUM_CORES'(1) << core;

    // one counter slice per cluster
    for (genvar g = 0; g < NUM_CL; g++) begin : g_cl
        always_comb begin
            if (hit)
                new_cnts[g*CNT_W +: CNT_W] = (cl == CL_W'(g)) ? inc : old_cnts[g*CNT_W +: CNT_W];
            else
                new_cnts[g*CNT_W +: CNT_W] = (cl == CL_W'(g)) ? CNT_W'(1) : '0;
        end
    end

    // incremental top/second tracking: only one counter moves per access
    always_comb begin
        if (!hit) begin
            new_top   = CNT_W'(1);
            new_sec   = '0;
            new_topid = cl;
        end else if (cl == old_topid) begin
            new_top   = inc;
            new_sec   = old_sec;
            new_topid = old_topid;
        end else if (inc > old_top) begin
            new_top   = inc;
            new_sec   = old_top;
            new_topid = cl;
        end else begin
            new_top   = old_top;
            new_topid = old_topid;
            new_sec   = (inc > old_sec) ? inc : old_sec;
        end
    end

    always_comb begin
        if (!hit) begin
            new_vec   = bit_me;
            new_pop   = POP_W'(1);
            new_since = '0;
        end else if ((old_vec & bit_me) != '0) begin
            new_vec   = old_vec;
            new_pop   = old_pop;
            new_since = (old_since == {SINCE_W{1'b1}}) ? old_since : old_since + 1'b1;
        end else begin
            new_vec   = old_vec | bit_me;
            new_pop   = old_pop + 1'b1;
            new_since = '0;
        end
    end
endmodule

// File: rtl/pact_rule_check.sv
module pact_rule_check #(
    parameter int CNT_W   = 6,
    parameter int SINCE_W = 8,
    parameter int POP_W   = 4,
    parameter int CL_W    = 2
) (
    input  logic               home_local,
    input  logic [CL_W-1:0]    req_cl,
    input  logic [CNT_W-1:0]   top,
    input  logic [CNT_W-1:0]   sec,
    input  logic [CL_W-1:0]    topid,
    input  logic [POP_W-1:0]   pop,
    input  logic [SINCE_W-1:0] since,
    input  logic [CNT_W-1:0]   thr_gap,
    input  logic [SINCE_W-1:0] thr_since,
    output logic               migrate,
    output logic               sharer_mode
);
    logic [CNT_W-1:0] gap;
    logic             shared_ok;
    logic             solo_ok;

    assign gap       = top - sec;
    assign shared_ok = (pop > POP_W'(1)) && (gap < thr_gap) && (since > thr_since);
    assign solo_ok   = ((pop == POP_W'(1)) || (gap >= thr_gap)) && (topid == req_cl);

    assign migrate     = !home_local && (shared_ok || solo_ok);
    assign sharer_mode = migrate && shared_ok;
endmodule

// File: rtl/pact_migrate_trigger.sv
module pact_migrate_trigger
    import pact_pkg::*;
#(
    parameter int NUM_CORES = 8,
    parameter int PAGE_W    = 20,
    parameter int SETS      = 16,
    parameter int WAYS      = 4,
    parameter int CNT_W     = 6,
    parameter int SINCE_W   = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [$clog2(NUM_CORES)-1:0]  req_core,
    input  logic [PAGE_W-1:0]             req_page,
    input  logic                          req_home_local,
    input  logic [CNT_W-1:0]              thr_gap,
    input  logic [SINCE_W-1:0]            thr_since,
    output logic                          dec_valid,
    output logic                          dec_migrate,
    output logic                          dec_sharer_mode,
    output logic [NUM_CORES-1:0]          dec_sharers
);
    localparam int CORE_W = $clog2(NUM_CORES);
    localparam int NUM_CL = NUM_CORES / 2;
    localparam int CL_W   = CORE_W - 1;
    localparam int SET_W  = $clog2(SETS);
    localparam int TAG_W  = PAGE_W - SET_W;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int AGE_W  = WAY_W;
    localparam int POP_W  = $clog2(NUM_CORES + 1);
    localparam int CNTS_W = NUM_CL * CNT_W;

    // ---------------- controller ----------------
    pact_state_e      state_q, state_d;
    logic [SET_W-1:0] sweep_q;
    logic             accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_INIT;
            sweep_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_INIT)
                sweep_q <= sweep_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT: if (sweep_q == SET_W'(SETS - 1)) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_INIT;
        endcase
    end

    assign accept = req_valid && (state_q == ST_RUN);

    // ---------------- table storage ----------------
    logic                 valid_q [SETS][WAYS];
    logic [TAG_W-1:0]     tag_q   [SETS][WAYS];
    logic [CNTS_W-1:0]    cnt_q   [SETS][WAYS];
    logic [CNT_W-1:0]     top_q   [SETS][WAYS];
    logic [CNT_W-1:0]     sec_q   [SETS][WAYS];
    logic [CL_W-1:0]      topid_q [SETS][WAYS];
    logic [NUM_CORES-1:0] vec_q   [SETS][WAYS];
    logic [POP_W-1:0]     pop_q   [SETS][WAYS];
    logic [SINCE_W-1:0]   since_q [SETS][WAYS];
    logic [AGE_W-1:0]     age_q   [SETS][WAYS];

    logic [SET_W-1:0] set_idx;
    logic [TAG_W-1:0] req_tag;
    assign set_idx = req_page[SET_W-1:0];
    assign req_tag = req_page[PAGE_W-1:SET_W];

    logic [WAYS-1:0] hit_vec, inv_vec, old_vec;
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit_vec[w] = valid_q[set_idx][w] && (tag_q[set_idx][w] == req_tag);
        assign inv_vec[w] = !valid_q[set_idx][w];
        assign old_vec[w] = (age_q[set_idx][w] == AGE_W'(WAYS - 1));
    end

    logic             hit_any;
    logic [WAY_W-1:0] hit_way, inv_way, lru_way, sel_way;

    always_comb begin
        hit_any = |hit_vec;
        hit_way = '0;
        inv_way = '0;
        lru_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (hit_vec[w]) hit_way = WAY_W'(w);
        for (int w = WAYS - 1; w >= 0; w--)
            if (inv_vec[w]) inv_way = WAY_W'(w);
        for (int w = 0; w < WAYS; w++)
            if (old_vec[w]) lru_way = WAY_W'(w);
        if (hit_any)        sel_way = hit_way;
        else if (|inv_vec)  sel_way = inv_way;
        else                sel_way = lru_way;
    end

    // ---------------- entry update and rule ----------------
    logic [CNTS_W-1:0]    new_cnts;
    logic [CNT_W-1:0]     new_top, new_sec;
    logic [CL_W-1:0]      new_topid;
    logic [NUM_CORES-1:0] new_vec;
    logic [POP_W-1:0]     new_pop;
    logic [SINCE_W-1:0]   new_since;
    logic                 rule_mig, rule_shared;

    pact_entry_update #(
        .NUM_CORES(NUM_CORES), .CNT_W(CNT_W), .SINCE_W(SINCE_W)
    ) u_update (
        .hit       (hit_any),
        .core      (req_core),
        .old_cnts  (cnt_q[set_idx][sel_way]),
        .old_top   (top_q[set_idx][sel_way]),
        .old_sec   (sec_q[set_idx][sel_way]),
        .old_topid (topid_q[set_idx][sel_way]),
        .old_vec   (vec_q[set_idx][sel_way]),
        .old_pop   (pop_q[set_idx][sel_way]),
        .old_since (since_q[set_idx][sel_way]),
        .new_cnts  (new_cnts),
        .new_top   (new_top),
        .new_sec   (new_sec),
        .new_topid (new_topid),
        .new_vec   (new_vec),
        .new_pop   (new_pop),
        .new_since (new_since)
    );

    pact_rule_check #(
        .CNT_W(CNT_W), .SINCE_W(SINCE_W), .POP_W(POP_W), .CL_W(CL_W)
    ) u_rule (
        .home_local  (req_home_local),
        .req_cl      (req_core[CORE_W-1:1]),
        .top         (new_top),
        .sec         (new_sec),
        .topid       (new_topid),
        .pop         (new_pop),
        .since       (new_since),
        .thr_gap     (thr_gap),
        .thr_since   (thr_since),
        .migrate     (rule_mig),
        .sharer_mode (rule_shared)
    );

    // storage writes: init sweep or accepted request
    always_ff @(posedge clk) begin
        if (state_q == ST_INIT) begin
            for (int w = 0; w < WAYS; w++) begin
                valid_q[sweep_q][w] <= 1'b0;
                age_q[sweep_q][w]   <= AGE_W'(w);
            end
        end else if (accept) begin
            valid_q[set_idx][sel_way] <= 1'b1;
            tag_q[set_idx][sel_way]   <= req_tag;
            cnt_q[set_idx][sel_way]   <= new_cnts;
            top_q[set_idx][sel_way]   <= new_top;
            sec_q[set_idx][sel_way]   <= new_sec;
            topid_q[set_idx][sel_way] <= new_topid;
            vec_q[set_idx][sel_way]   <= new_vec;
            pop_q[set_idx][sel_way]   <= new_pop;
            since_q[set_idx][sel_way] <= new_since;
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == sel_way)
                    age_q[set_idx][w] <= '0;
                else if (age_q[set_idx][w] < age_q[set_idx][sel_way])
                    age_q[set_idx][w] <= age_q[set_idx][w] + 1'b1;
            end
        end
    end

    // registered decision outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_valid       <= 1'b0;
            dec_migrate     <= 1'b0;
            dec_sharer_mode <= 1'b0;
            dec_sharers     <= '0;
        end else begin
            dec_valid       <= accept;
            dec_migrate     <= accept && rule_mig;
            dec_sharer_mode <= accept && rule_shared;
            dec_sharers     <= accept ? new_vec : '0;
        end
    end

    // ---------------- assertions ----------------
    // R1
    init_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT) |=> !dec_valid);

    // R2
    dec_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(req_valid && (state_q == ST_RUN)));

    // R2
    req_gets_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> dec_valid);

    // R3
    local_no_mig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_migrate |-> !$past(req_home_local));

    // R10
    mode_implies_mig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_sharer_mode |-> dec_migrate);

    // R10
    requester_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> dec_sharers[$past(req_core)]);

    // R5
    pop_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit_any) |-> ($countones(vec_q[set_idx][sel_way]) == int'(pop_q[set_idx][sel_way])));

    // R7
    rank_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit_any) |-> (sec_q[set_idx][sel_way] <= top_q[set_idx][sel_way]));
endmodule

// File: tb/pact_migrate_trigger_tb.sv
module pact_migrate_trigger_tb_top;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [2:0]  req_core;
    logic [19:0] req_page;
    logic        req_home_local;
    logic [5:0]  thr_gap;
    logic [7:0]  thr_since;
    logic        dec_valid, dec_migrate, dec_sharer_mode;
    logic [7:0]  dec_sharers;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_NS/2) clk = ~clk;

    pact_migrate_trigger dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_core(req_core),
        .req_page(req_page), .req_home_local(req_home_local), .thr_gap(thr_gap),
        .thr_since(thr_since), .dec_valid(dec_valid), .dec_migrate(dec_migrate),
        .dec_sharer_mode(dec_sharer_mode), .dec_sharers(dec_sharers)
    );

    typedef struct packed {
        logic [2:0]  core;
        logic [19:0] page;
        logic        hl;
        logic        mig;
        logic        mode;
        logic [7:0]  vec;
    } vec_t;

    // thresholds gap=3, since=2 ; page 0x00011 in set 1, 0x00022 in set 2
    localparam vec_t VECS [19] = '{
        '{3'd0, 20'h00011, 1'b0, 1'b1, 1'b0, 8'h01},
        '{3'd0, 20'h00011, 1'b1, 1'b0, 1'b0, 8'h01},
        '{3'd2, 20'h00011, 1'b0, 1'b0, 1'b0, 8'h05},
        '{3'd3, 20'h00011, 1'b0, 1'b0, 1'b0, 8'h0D},
        '{3'd2, 20'h00011, 1'b0, 1'b0, 1'b0, 8'h0D},
        '{3'd2, 20'h00011, 1'b0, 1'b0, 1'b0, 8'h0D},
        '{3'd0, 20'h00011, 1'b0, 1'b1, 1'b1, 8'h0D},
        '{3'd2, 20'h00011, 1'b0, 1'b1, 1'b1, 8'h0D},
        '{3'd3, 20'h00011, 1'b0, 1'b1, 1'b0, 8'h0D},
        '{3'd0, 20'h00011, 1'b0, 1'b1, 1'b1, 8'h0D},
        '{3'd2, 20'h00011, 1'b1, 1'b0, 1'b0, 8'h0D},
        '{3'd0, 20'h00011, 1'b0, 1'b1, 1'b1, 8'h0D},
        '{3'd4, 20'h00022, 1'b0, 1'b1, 1'b0, 8'h10},
        '{3'd4, 20'h00022, 1'b0, 1'b1, 1'b0, 8'h10},
        '{3'd4, 20'h00022, 1'b0, 1'b1, 1'b0, 8'h10},
        '{3'd4, 20'h00022, 1'b0, 1'b1, 1'b0, 8'h10},
        '{3'd6, 20'h00022, 1'b0, 1'b0, 1'b0, 8'h50},
        '{3'd7, 20'h00022, 1'b0, 1'b0, 1'b0, 8'hD0},
        '{3'd4, 20'h00022, 1'b0, 1'b1, 1'b0, 8'hD0}
    };

    task automatic check_eq(input string what, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %0h expected %0h", what, got, exp);
        end
    endtask

    // drive at falling edge, sample at the next falling edge (one rising edge later)
    task automatic do_req(input logic [2:0] c, input logic [19:0] p, input logic hl);
        @(negedge clk);
        req_valid = 1'b1; req_core = c; req_page = p; req_home_local = hl;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_dec(input string tag, input logic mig, input logic mode, input logic [7:0] v);
        check_eq({tag, " dec_valid"}, 32'(dec_valid), 32'd1);
        check_eq({tag, " dec_migrate"}, 32'(dec_migrate), 32'(mig));
        check_eq({tag, " dec_sharer_mode"}, 32'(dec_sharer_mode), 32'(mode));
        check_eq({tag, " dec_sharers"}, 32'(dec_sharers), 32'(v));
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_core = '0; req_page = '0;
        req_home_local = 1'b0; thr_gap = 6'd3; thr_since = 8'd2;
        repeat (3) @(negedge clk);
        // R1 reset values
        check_eq("R1 reset dec_valid", 32'(dec_valid), 32'd0);
        check_eq("R1 reset dec_migrate", 32'(dec_migrate), 32'd0);
        check_eq("R1 reset dec_sharers", 32'(dec_sharers), 32'd0);
        rst_n = 1'b1;
        // R1 requests during init sweep are ignored
        for (int i = 0; i < 4; i++) begin
            req_valid = 1'b1; req_core = 3'd1; req_page = 20'h00011; req_home_local = 1'b0;
            @(negedge clk);
            check_eq("R1 init ignored dec_valid", 32'(dec_valid), 32'd0);
        end
        req_valid = 1'b0;
        repeat (20) @(negedge clk);

        // table walk: R3 R4 R5 R7 R8 R9 R10
        for (int i = 0; i < 19; i++) begin
            do_req(VECS[i].core, VECS[i].page, VECS[i].hl);
            expect_dec($sformatf("R8/R9/R10 vector %0d", i), VECS[i].mig, VECS[i].mode, VECS[i].vec);
        end
        // R2 idle cycle gives no decision
        @(negedge clk);
        check_eq("R2 idle dec_valid", 32'(dec_valid), 32'd0);

        // R4 LRU replacement in set 3 (home local so no moves: R3)
        do_req(3'd0, 20'h00103, 1'b1); expect_dec("R4 fill P1", 1'b0, 1'b0, 8'h01);
        do_req(3'd1, 20'h00203, 1'b1); expect_dec("R4 fill P2", 1'b0, 1'b0, 8'h02);
        do_req(3'd2, 20'h00303, 1'b1); expect_dec("R4 fill P3", 1'b0, 1'b0, 8'h04);
        do_req(3'd3, 20'h00403, 1'b1); expect_dec("R4 fill P4", 1'b0, 1'b0, 8'h08);
        do_req(3'd4, 20'h00103, 1'b1); expect_dec("R4 hit P1", 1'b0, 1'b0, 8'h11);
        do_req(3'd5, 20'h00503, 1'b1); expect_dec("R4 P5 evicts P2", 1'b0, 1'b0, 8'h20);
        do_req(3'd6, 20'h00203, 1'b1); expect_dec("R4 P2 refilled", 1'b0, 1'b0, 8'h40);
        do_req(3'd7, 20'h00103, 1'b1); expect_dec("R4 P1 kept", 1'b0, 1'b0, 8'h91);
        do_req(3'd1, 20'h00303, 1'b1); expect_dec("R4 P3 refilled", 1'b0, 1'b0, 8'h02);
        do_req(3'd0, 20'h00403, 1'b1); expect_dec("R4 P4 refilled", 1'b0, 1'b0, 8'h01);

        // R6 since-counter saturation, R11 new thresholds take effect
        thr_gap = 6'd3; thr_since = 8'd250;
        for (int i = 0; i < 300; i++) begin
            do_req((i % 2 == 0) ? 3'd0 : 3'd2, 20'h00044, 1'b0);
            if (i == 199) expect_dec("R11 since below threshold", 1'b0, 1'b0, 8'h05);
            if (i == 299) expect_dec("R6 since saturated", 1'b1, 1'b1, 8'h05);
        end

        // R7 cluster counter saturation
        thr_gap = 6'd60; thr_since = 8'd0;
        for (int i = 0; i < 70; i++) do_req(3'd0, 20'h00055, 1'b0);
        do_req(3'd2, 20'h00055, 1'b0); expect_dec("R7 new sharer", 1'b0, 1'b0, 8'h05);
        do_req(3'd2, 20'h00055, 1'b0); expect_dec("R7 saturated gap keeps solo", 1'b0, 1'b0, 8'h05);
        do_req(3'd0, 20'h00055, 1'b0); expect_dec("R9 top cluster solo", 1'b1, 1'b0, 8'h05);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule